// File: doc/BRIEF.md
# Write-Completion Status Read Path

This block is the read-side data multiplexer of a byte-wide nonvolatile memory model. With no internal programming period running, a read returns the array byte that the surrounding model presents for the read address. While the programming timer is busy, a read returns a status byte instead, so the host can find out when the write has finished. The most significant bit carries the inverted top bit of the last byte written. The next bit flips each time a new read begins. The remaining bits repeat the last byte written.

A read is recognised when chip-enable and output-enable are both low and write-enable is high. Either enable can be cycled to start a fresh read. All inputs are sampled on the clock, and the data and tri-state enable are registered outputs. A parameter chooses whether every read during the busy period is a status read, or only a read aimed at the address of the last byte written.

Top module: `rdpoll_path`

## Requirements
- R1: `dout_oe` is 1 on the cycle after a clock edge that samples `ce_n`=0, `oe_n`=0 and `we_n`=1, and is 0 after any other sample. Whenever `dout_oe` is 0, `dout` is 0.
- R2: A read sampled with `busy`=0 presents `array_rdata` on `dout` one cycle later. When the read is held, the output follows new addresses and data cycle by cycle.
- R3: A status read (a read sampled with `busy`=1, in the default mode) presents the inverse of bit 7 of `last_wdata` on `dout[7]`.
- R4: On a status read, `dout[6]` carries the toggle state and `dout[5:0]` equal `last_wdata[5:0]`.
- R5: The toggle state inverts when a status read begins, that is, when the read condition is sampled after a sample without it. It keeps its value while a read is held, including a read that was already active when `busy` rose.
- R6: The toggle state does not change while `busy`=0. The next status read continues from the value it last had.
- R7: Reset clears the toggle state to 0, so the first status read after reset shows `dout[6]`=1.
- R8: A new status read can be started either by raising and lowering `oe_n` alone or by raising and lowering `ce_n` alone.
- R9: Once `busy` is sampled low, a read that is held across that edge shows `array_rdata` on the next cycle.
- R10: A write strobe (`we_n`=0) never drives the bus and never changes the toggle state, even when `busy`=1.
- R11: With `POLL_ANY_ADDR`=0, only a busy read whose `rd_addr` equals `last_waddr` is a status read and can flip the toggle. A busy read at any other address returns `array_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_addr | input | ADDR_W | Read address |
| array_rdata | input | DATA_W | Array byte at the read address |
| busy | input | 1 | Internal programming period running |
| last_wdata | input | DATA_W | Last byte written |
| last_waddr | input | ADDR_W | Address of the last byte written |
| dout | output | DATA_W | Read data or status byte |
| dout_oe | output | 1 | Drive enable for the bidirectional data pins |

## Verification
Both results are registered. `dout` and `dout_oe` reflect the strobes, `busy`, the addresses and the data sampled at one rising edge, and they become valid right after that edge. A read start seen at an edge flips the toggle in the same update, so the byte that appears then already shows the new bit 6. The bench changes inputs only just after a falling edge. It compares both instances against its model at the next falling edge, which is exactly one register stage after the sample. Named checks confirm the toggle sequence across the oe-only restart, the ce-only restart, the idle gap and a busy rise during a held read.

// File: rtl/rdpoll_pkg.sv
package rdpoll_pkg;

    // Source that feeds the output register on a given cycle
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } src_e;

endpackage

// File: rtl/rdpoll_strobe.sv
module rdpoll_strobe (
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic prev_rd,
    output logic rd_act,
    output logic rd_start
);

    always_comb begin
        rd_act   = !ce_n && !oe_n && we_n;
        // falling edge of the combined active-low read strobe
        rd_start = rd_act && !prev_rd;
    end

endmodule

// File: rtl/rdpoll_select.sv
module rdpoll_select
    import rdpoll_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter bit POLL_ANY_ADDR = 1'b1
) (
    input  logic              busy,
    input  logic              rd_act,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_waddr,
    output src_e              src
);

    logic addr_hit;
    logic poll_ok;

    always_comb begin
        addr_hit = (rd_addr == last_waddr);
        poll_ok  = POLL_ANY_ADDR ? 1'b1 : addr_hit;
        if (!rd_act)
            src = SRC_NONE;
        else if (busy && poll_ok)
            src = SRC_STATUS;
        else
            src = SRC_ARRAY;
    end

endmodule

// File: rtl/rdpoll_status.sv
module rdpoll_status #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] last_wdata,
    input  logic              tog,
    output logic [DATA_W-1:0] stat_byte
);

    localparam int HI_POS  = DATA_W - 1;
    localparam int TOG_POS = DATA_W - 2;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == HI_POS) begin : g_inv
            assign stat_byte[i] = ~last_wdata[i];
        end else if (i == TOG_POS) begin : g_tog
            assign stat_byte[i] = tog;
        end else begin : g_pass
            assign stat_byte[i] = last_wdata[i];
        end
    end

endmodule

// File: rtl/rdpoll_path.sv
module rdpoll_path
    import rdpoll_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int ADDR_W        = 15,
    parameter bit POLL_ANY_ADDR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_wdata,
    input  logic [ADDR_W-1:0] last_waddr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    localparam int HI_POS  = DATA_W - 1;
    localparam int TOG_POS = DATA_W - 2;

    typedef struct packed {
        logic              rd_act;
        logic              tog;
        logic              oe;
        logic [DATA_W-1:0] dout;
    } state_t;

    state_t            st_d;
    state_t            st_q;
    logic              rd_act;
    logic              rd_start;
    src_e              src;
    logic              tog_nxt;
    logic [DATA_W-1:0] stat_byte;

    rdpoll_strobe u_strobe (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .prev_rd  (st_q.rd_act),
        .rd_act   (rd_act),
        .rd_start (rd_start)
    );

    rdpoll_select #(
        .ADDR_W        (ADDR_W),
        .POLL_ANY_ADDR (POLL_ANY_ADDR)
    ) u_select (
        .busy       (busy),
        .rd_act     (rd_act),
        .rd_addr    (rd_addr),
        .last_waddr (last_waddr),
        .src        (src)
    );

    // toggle flips only when a status read begins
    assign tog_nxt = st_q.tog ^ (rd_start && (src == SRC_STATUS));

    rdpoll_status #(
        .DATA_W (DATA_W)
    ) u_status (
        .last_wdata (last_wdata),
        .tog        (tog_nxt),
        .stat_byte  (stat_byte)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rd_act = rd_act;
        st_d.tog    = tog_nxt;
        st_d.oe     = (src != SRC_NONE);
        unique case (src)
            SRC_STATUS: st_d.dout = stat_byte;
            SRC_ARRAY:  st_d.dout = array_rdata;
            default:    st_d.dout = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dout    = st_q.dout;
    assign dout_oe = st_q.oe;

    // ---------------- assertions ----------------
    assert_bus_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0));

    assert_drive_on_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> dout_oe);

    assert_idle_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ce_n && !oe_n && we_n) |=> (dout == $past(array_rdata)));

    assert_poll_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_STATUS) |=> (dout[HI_POS] == ~$past(last_wdata[HI_POS])));

    assert_poll_tog_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_STATUS) |=> (dout[TOG_POS] == st_q.tog));

    assert_flip_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && src == SRC_STATUS) |=> (st_q.tog != $past(st_q.tog)));

    assert_tog_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(st_q.tog));

    assert_no_write_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> (!dout_oe && $stable(st_q.tog)));

endmodule

// File: tb/test_rdpoll_path.sv
module test_rdpoll_path;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [14:0] rd_addr = '0;
    logic [7:0]  array_rdata = '0;
    logic        busy = 1'b0;
    logic [7:0]  last_wdata = '0;
    logic [14:0] last_waddr = '0;
    logic [7:0]  dout_a;
    logic        oe_a;
    logic [7:0]  dout_m;
    logic        oe_m;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // reference model state: index 0 = poll on any address, 1 = address match
    bit       m_tog [2];
    bit       m_prev[2];
    bit [7:0] m_exp [2];
    bit       m_oe  [2];
    bit       m_poll[2];

    always #4 clk = ~clk;

    rdpoll_path i_rdpoll_path (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rd_addr(rd_addr), .array_rdata(array_rdata), .busy(busy),
        .last_wdata(last_wdata), .last_waddr(last_waddr),
        .dout(dout_a), .dout_oe(oe_a)
    );

    rdpoll_path #(.POLL_ANY_ADDR(1'b0)) i_rdpoll_path_match (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rd_addr(rd_addr), .array_rdata(array_rdata), .busy(busy),
        .last_wdata(last_wdata), .last_waddr(last_waddr),
        .dout(dout_m), .dout_oe(oe_m)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic model(input int k, input bit any_addr);
        bit rd;
        bit poll;
        rd   = !ce_n && !oe_n && we_n;
        poll = rd && busy && (any_addr || rd_addr == last_waddr);
        if (poll && !m_prev[k]) m_tog[k] = !m_tog[k];
        m_prev[k] = rd;
        m_poll[k] = poll;
        m_oe[k]   = rd;
        if (!rd)       m_exp[k] = 8'h00;
        else if (poll) m_exp[k] = {~last_wdata[7], m_tog[k], last_wdata[5:0]};
        else           m_exp[k] = array_rdata;
    endtask

    task automatic step(input bit c, input bit o, input bit w,
                        input logic [14:0] a, input logic [7:0] arr, input bit b);
        ce_n = c; oe_n = o; we_n = w;
        rd_addr = a; array_rdata = arr; busy = b;
        model(0, 1'b1);
        model(1, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check(m_oe[0] ? "R1 oe" : "R1 oe idle", {7'd0, oe_a}, {7'd0, m_oe[0]});
        check(!m_oe[0] ? "R1 quiet" : (m_poll[0] ? "R4 status" : "R2 data"), dout_a, m_exp[0]);
        if (m_poll[0]) check("R3 msb", {7'd0, dout_a[7]}, {7'd0, ~last_wdata[7]});
        check("R11 match-mode oe", {7'd0, oe_m}, {7'd0, m_oe[1]});
        check("R11 match-mode data", dout_m, m_exp[1]);
    endtask

    initial begin
        m_tog  = '{0, 0};
        m_prev = '{0, 0};
        last_wdata = 8'hA5;
        last_waddr = 15'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset oe", {7'd0, oe_a}, 8'h00);
        check("R1 reset data", dout_a, 8'h00);

        step(1, 1, 1, 15'h0000, 8'h00, 0);
        step(0, 0, 1, 15'h0010, 8'h5A, 0);
        check("R2 idle read", dout_a, 8'h5A);
        step(0, 0, 1, 15'h0011, 8'hC3, 0);
        check("R2 held read follows", dout_a, 8'hC3);
        step(1, 1, 1, 15'h0011, 8'hC3, 0);

        // write strobes while busy
        step(0, 1, 0, 15'h1234, 8'h00, 1);
        check("R10 write no drive", {7'd0, oe_a}, 8'h00);
        step(0, 0, 0, 15'h1234, 8'h00, 1);
        check("R10 we low blocks read", {7'd0, oe_a}, 8'h00);
        step(1, 1, 1, 15'h1234, 8'h00, 1);

        // first status read after reset, off the written address
        step(0, 0, 1, 15'h0200, 8'h77, 1);
        check("R7 first status read", dout_a, 8'h65);
        check("R11 other address gives array", dout_m, 8'h77);
        step(0, 0, 1, 15'h0200, 8'h77, 1);
        step(0, 0, 1, 15'h0200, 8'h77, 1);
        check("R5 held read keeps toggle", {7'd0, dout_a[6]}, 8'h01);

        // restart via output-enable only
        step(0, 1, 1, 15'h1234, 8'h77, 1);
        step(0, 0, 1, 15'h1234, 8'h77, 1);
        check("R8 oe restart flips", dout_a, 8'h25);
        check("R11 match address polls", dout_m, 8'h65);

        // restart via chip-enable only
        step(1, 0, 1, 15'h1234, 8'h77, 1);
        step(0, 0, 1, 15'h1234, 8'h77, 1);
        check("R8 ce restart flips", dout_a, 8'h65);

        // programming ends during a held read
        step(0, 0, 1, 15'h1234, 8'h9E, 0);
        check("R9 true data after busy", dout_a, 8'h9E);

        // idle reads leave the toggle alone
        step(1, 1, 1, 15'h1234, 8'h9E, 0);
        step(0, 0, 1, 15'h0001, 8'h12, 0);
        step(1, 1, 1, 15'h0001, 8'h12, 0);
        last_wdata = 8'h3C;
        step(0, 0, 1, 15'h1234, 8'h11, 1);
        check("R6 toggle continues", {7'd0, dout_a[6]}, 8'h00);
        check("R3 msb inverted", {7'd0, dout_a[7]}, 8'h01);
        check("R4 low bits", {2'd0, dout_a[5:0]}, 8'h3C);

        // busy rises during a read already in progress
        step(1, 1, 1, 15'h1234, 8'h11, 0);
        step(0, 0, 1, 15'h1234, 8'h44, 0);
        step(0, 0, 1, 15'h1234, 8'h44, 1);
        check("R5 no flip on busy rise", dout_a, 8'hBC);
        step(1, 1, 1, 15'h1234, 8'h44, 1);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule